// File: doc/BRIEF.md
# Command/Data Byte Port for a Conferencing Device

This block is the processor-facing side of a PCM conferencing device. An external host drives an 8-bit bus with asynchronous, active-low strobes: a chip select, a read strobe and a write strobe. A single select line gives each transfer its meaning. On a write, the line decides whether the byte is an opcode or a data operand. On a read, it picks one of two banks of per-channel overflow flags.

All three write-side inputs, and the bus byte, pass through a two-stage synchroniser into the system clock domain. A write completes on the rising edge of the write strobe. The byte that was held on the bus while the strobe was low is then stored in the opcode register or in the data register. A one-cycle pulse on the matching valid output announces it to the instruction logic that follows.

The read side has no clock in its path. The output byte and its enable follow the pins directly, so the host sees data from the falling edge of the read strobe onward. The ten overflow flags come in as a port. Opcode decoding and the conferencing datapath sit elsewhere.

Top module: `cd_port`

## Requirements
- R1: A write accepted with `cmd_sel` high (1 = opcode) loads the bus byte into `opcode_q` and leaves `data_q` unchanged.
- R2: A write accepted with `cmd_sel` low (0 = data) loads the bus byte into `data_q` and leaves `opcode_q` unchanged.
- R3: The stored value is the byte held on `bus_in` while `wr_n` was low. It appears on `opcode_q`/`data_q` at the third rising clock edge after `wr_n` rises, and not before.
- R4: Each accepted write raises exactly one of `opcode_valid`/`data_valid` for exactly one clock cycle, in the same cycle the register updates. The register outputs change only in such a cycle.
- R5: A write strobe given while `cs_n` is high changes neither register and raises no valid pulse.
- R6: With `rst_n`, `cs_n` and `rd_n` in the driving state and `cmd_sel` low, `bus_out` equals `ovf_flags[7:0]`. Bus bit 0 is the least significant bit and carries channel 0.
- R7: With the bus driven and `cmd_sel` high, `bus_out[1:0]` equals `ovf_flags[9:8]` and `bus_out[7:2]` reads zero.
- R8: `bus_oe` is high exactly when `rst_n` is high, `cs_n` is low and `rd_n` is low, with no clock delay. While it is low, `bus_out` is zero.
- R9: A clock edge with `rst_n` low clears `opcode_q` and `data_q` to zero and holds both valid outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; also floats the bus |
| cs_n | input | 1 | Active-low chip select from the host |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe; byte taken at its rising edge |
| cmd_sel | input | 1 | Write: 1 opcode, 0 data. Read: 1 flags 9..8, 0 flags 7..0 |
| bus_in | input | 8 | Byte the host drives during a write |
| bus_out | output | 8 | Byte returned to the host during a read |
| bus_oe | output | 1 | High while the block drives the bus |
| ovf_flags | input | 10 | Per-channel overflow flags, bit n = channel n |
| opcode_q | output | 8 | Last opcode byte written |
| data_q | output | 8 | Last data byte written |
| opcode_valid | output | 1 | One-cycle pulse when opcode_q is loaded |
| data_valid | output | 1 | One-cycle pulse when data_q is loaded |

## Verification
The two sides have different latencies. A write result is due on the third clock edge after `wr_n` rises: two synchroniser stages, then the commit register. The read byte and `bus_oe` are due in the same cycle the pins change. The bench model queues each accepted write with a due cycle of the drive cycle plus three, and the pulse is expected only in that cycle. It computes the read outputs from the present pin values. Every output is compared on every falling clock edge, so a result that arrives early or late fails in the cycle where it differs.

// File: rtl/cdp_pkg.sv
// Package: shared types of the command/data port.
// Assumes: nothing beyond IEEE 1800-2017.
package cdp_pkg;

    // Meaning of the select line on a write
    typedef enum logic {
        SEL_DATA   = 1'b0,
        SEL_OPCODE = 1'b1
    } wr_kind_e;

    // Bank chosen by the select line on a read
    typedef enum logic {
        BANK_LOW  = 1'b0,
        BANK_HIGH = 1'b1
    } rd_bank_e;

endpackage

// File: rtl/cdp_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous pins.
// Assumes: each bit is an independent level; a multi-bit value is only
// used once it has been stable for longer than STAGES cycles.
module cdp_sync #(
    parameter int               WIDTH     = 1,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Sample the raw pins into the first stage
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= RESET_VAL;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // Pass each stage on to the next
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= RESET_VAL;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/cdp_wr_capture.sv
// Module: turns synchronised write strobes into opcode/data register loads.
// Assumes: the inputs are already in the clk domain, and the host holds the
// select line and the byte steady for the whole time the strobe is low.
module cdp_wr_capture
    import cdp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              wr_n_s,
    input  logic              sel_s,
    input  logic [DATA_W-1:0] data_s,
    output logic [DATA_W-1:0] opcode_q,
    output logic [DATA_W-1:0] data_q,
    output logic              opcode_valid,
    output logic              data_valid
);

    logic              wr_prev;
    logic              held_cs_n;
    wr_kind_e          held_kind;
    logic [DATA_W-1:0] held_byte;
    logic              wr_rise;
    logic              accept;

    // Remember the strobe level and, while it is low, the transfer fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_prev   <= 1'b1;
            held_cs_n <= 1'b1;
            held_kind <= SEL_DATA;
            held_byte <= '0;
        end else begin
            wr_prev <= wr_n_s;
            if (!wr_n_s) begin
                held_cs_n <= cs_n_s;
                held_kind <= wr_kind_e'(sel_s);
                held_byte <= data_s;
            end
        end
    end

    assign wr_rise = wr_n_s & ~wr_prev;
    assign accept  = wr_rise & ~held_cs_n;

    // Commit the held byte and raise the matching pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode_q     <= '0;
            data_q       <= '0;
            opcode_valid <= 1'b0;
            data_valid   <= 1'b0;
        end else begin
            opcode_valid <= accept && (held_kind == SEL_OPCODE);
            data_valid   <= accept && (held_kind == SEL_DATA);
            if (accept && held_kind == SEL_OPCODE) opcode_q <= held_byte;
            if (accept && held_kind == SEL_DATA)   data_q   <= held_byte;
        end
    end

    // R4
    valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(opcode_valid && data_valid));

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_valid || data_valid) |=> !(opcode_valid || data_valid));

    // R1
    opcode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(opcode_q) |-> opcode_valid);

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_q) |-> data_valid);

    // R5
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rise && held_cs_n) |=> !(opcode_valid || data_valid));

endmodule

// File: rtl/cdp_rd_mux.sv
// Module: combinational read path that returns one bank of overflow flags.
// Assumes: DATA_W < CHAN_N <= 2*DATA_W, so one select bit reaches both banks.
module cdp_rd_mux
    import cdp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CHAN_N = 10
) (
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              bank_sel,
    input  logic [CHAN_N-1:0] flags,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);

    localparam int PAD_W = 2 * DATA_W - CHAN_N;

    logic [2*DATA_W-1:0] flags_ext;
    logic [DATA_W-1:0]   bank_byte;

    generate
        if (PAD_W > 0) begin : g_pad
            assign flags_ext = {{PAD_W{1'b0}}, flags};
        end else begin : g_nopad
            assign flags_ext = flags;
        end
    endgenerate

    // Pick the bank named by the select line and gate it with the enable
    always_comb begin
        bus_oe    = rst_n & ~cs_n & ~rd_n;
        bank_byte = (rd_bank_e'(bank_sel) == BANK_HIGH) ? flags_ext[2*DATA_W-1:DATA_W]
                                                        : flags_ext[DATA_W-1:0];
        bus_out   = bus_oe ? bank_byte : '0;
    end

    // Check the padding of the high bank against the flag count
    always_comb begin
        // R7
        if (rst_n && bus_oe && bank_sel)
            high_bank_pad_chk: assert ((bus_out >> (CHAN_N - DATA_W)) == '0);
    end

endmodule

// File: rtl/cd_port.sv
// Module: host byte port that sorts writes into opcode or data and returns
// overflow flags on reads.
// Assumes: host strobes are asynchronous to clk; the flags are in the clk
// domain; the bus pins are shared through bus_out/bus_oe outside this block.
module cd_port #(
    parameter int DATA_W      = 8,
    parameter int CHAN_N      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              cmd_sel,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [CHAN_N-1:0] ovf_flags,
    output logic [DATA_W-1:0] opcode_q,
    output logic [DATA_W-1:0] data_q,
    output logic              opcode_valid,
    output logic              data_valid
);

    localparam int                 SYNC_W    = DATA_W + 3;
    localparam logic [SYNC_W-1:0]  SYNC_IDLE = {2'b11, {(DATA_W + 1){1'b0}}};

    logic [SYNC_W-1:0] pins_raw;
    logic [SYNC_W-1:0] pins_s;

    assign pins_raw = {cs_n, wr_n, cmd_sel, bus_in};

    cdp_sync #(
        .WIDTH     (SYNC_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (SYNC_IDLE)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    cdp_wr_capture #(
        .DATA_W (DATA_W)
    ) i_wr (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n_s       (pins_s[SYNC_W-1]),
        .wr_n_s       (pins_s[SYNC_W-2]),
        .sel_s        (pins_s[DATA_W]),
        .data_s       (pins_s[DATA_W-1:0]),
        .opcode_q     (opcode_q),
        .data_q       (data_q),
        .opcode_valid (opcode_valid),
        .data_valid   (data_valid)
    );

    cdp_rd_mux #(
        .DATA_W (DATA_W),
        .CHAN_N (CHAN_N)
    ) i_rd (
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .bank_sel (cmd_sel),
        .flags    (ovf_flags),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe)
    );

    // R8
    float_chk: assert property (@(posedge clk)
        (!rst_n || cs_n) |-> (!bus_oe && bus_out == '0));

endmodule

// File: tb/test_cd_port.sv
module test_cd_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       cmd_sel = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic [9:0] ovf_flags = 10'h000;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic [7:0] opcode_q;
    logic [7:0] data_q;
    logic       opcode_valid;
    logic       data_valid;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    int         due_q[$];
    bit         kind_q[$];
    logic [7:0] byte_q[$];
    logic [7:0] exp_op = 8'h00;
    logic [7:0] exp_dat = 8'h00;
    bit         exp_opv = 1'b0;
    bit         exp_dv = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cd_port i_cd_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .rd_n         (rd_n),
        .wr_n         (wr_n),
        .cmd_sel      (cmd_sel),
        .bus_in       (bus_in),
        .bus_out      (bus_out),
        .bus_oe       (bus_oe),
        .ovf_flags    (ovf_flags),
        .opcode_q     (opcode_q),
        .data_q       (data_q),
        .opcode_valid (opcode_valid),
        .data_valid   (data_valid)
    );

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    // Reference model and per-cycle comparison, on the falling edge
    always @(negedge clk) begin
        logic       e_oe;
        logic [7:0] e_out;
        cyc++;
        exp_opv = 1'b0;
        exp_dv  = 1'b0;
        if (!rst_n) begin
            exp_op = 8'h00;
            exp_dat = 8'h00;
            due_q.delete();
            kind_q.delete();
            byte_q.delete();
        end else begin
            while (due_q.size() > 0 && due_q[0] == cyc) begin
                void'(due_q.pop_front());
                if (kind_q.pop_front()) begin exp_op = byte_q.pop_front(); exp_opv = 1'b1; end
                else begin exp_dat = byte_q.pop_front(); exp_dv = 1'b1; end
            end
        end
        e_oe  = rst_n && !cs_n && !rd_n;
        e_out = !e_oe ? 8'h00 : (cmd_sel ? {6'b0, ovf_flags[9:8]} : ovf_flags[7:0]);
        if (!done) begin
            check_val("R1 R3 R9 opcode_q", opcode_q, exp_op);
            check_val("R2 R3 R9 data_q", data_q, exp_dat);
            check_val("R3 R4 opcode_valid", opcode_valid, exp_opv);
            check_val("R3 R4 data_valid", data_valid, exp_dv);
            check_val("R8 bus_oe", bus_oe, e_oe);
            check_val(cmd_sel ? "R7 R8 bus_out" : "R6 R8 bus_out", bus_out, e_out);
        end
    end

    task automatic do_write(input bit sel, input logic [7:0] v, input bit csn);
        @(negedge clk); #1; cs_n = csn; cmd_sel = sel; bus_in = v;
        @(negedge clk); #1; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        #1; wr_n = 1'b1;
        if (!csn) begin due_q.push_back(cyc + 3); kind_q.push_back(sel); byte_q.push_back(v); end
        repeat (3) @(negedge clk);
        #1; cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_read(input bit sel, input logic [9:0] f, input bit csn);
        @(negedge clk); #1; ovf_flags = f; cmd_sel = sel; cs_n = csn;
        @(negedge clk); #1; rd_n = 1'b0;
        repeat (2) @(negedge clk);
        #1; rd_n = 1'b1; cs_n = 1'b1;
    endtask

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] keep;
        repeat (4) @(negedge clk);
        #1; rst_n = 1'b1;
        @(negedge clk);
        check_val("R9 opcode_q after reset", opcode_q, 8'h00);
        check_val("R9 data_q after reset", data_q, 8'h00);

        do_write(1'b1, 8'hA5, 1'b0);   // R1
        do_write(1'b0, 8'h3C, 1'b0);   // R2
        do_write(1'b1, 8'hFF, 1'b0);
        do_write(1'b0, 8'h00, 1'b0);
        do_write(1'b0, 8'h81, 1'b0);
        do_write(1'b1, 8'h5A, 1'b0);

        // R5: strobe with chip deselected leaves both registers alone
        keep = data_q;
        do_write(1'b0, 8'h77, 1'b1);
        do_write(1'b1, 8'h66, 1'b1);
        repeat (3) @(negedge clk);
        check_val("R5 data_q after deselected write", data_q, keep);
        check_val("R5 opcode_q after deselected write", opcode_q, 8'h5A);

        // R6 / R7 / R8 reads across flag patterns
        do_read(1'b0, 10'h3FF, 1'b0);
        do_read(1'b1, 10'h3FF, 1'b0);
        do_read(1'b0, 10'h201, 1'b0);
        do_read(1'b1, 10'h201, 1'b0);
        do_read(1'b0, 10'h155, 1'b0);
        do_read(1'b1, 10'h2AA, 1'b0);
        do_read(1'b1, 10'h0FF, 1'b0);
        do_read(1'b0, 10'h3FF, 1'b1);  // R8 deselected read floats

        // R8: read strobe during reset floats the bus; R9 clears registers
        @(negedge clk); #1; rst_n = 1'b0; cs_n = 1'b0; rd_n = 1'b0; ovf_flags = 10'h3FF;
        repeat (2) @(negedge clk);
        check_val("R8 bus_oe in reset", bus_oe, 0);
        check_val("R9 opcode_q in reset", opcode_q, 8'h00);
        #1; rd_n = 1'b1; cs_n = 1'b1; rst_n = 1'b1;

        do_write(1'b0, 8'hC3, 1'b0);
        repeat (2) @(negedge clk);
        check_val("R2 data_q after reset", data_q, 8'hC3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule